// File: doc/BRIEF.md
# Multiword DMA Host Burst Engine

This block is the host side of a multiword DMA transfer on a 16-bit ATA data bus. Once a command has been loaded with a word count and a direction, it waits for the device to raise its DMA request. It then acknowledges the request and moves one word per read or write strobe pulse. Pulse widths, recovery gaps and acknowledge margins are counted in cycles of a 48 MHz engine clock. On the local side, words come from a valid/ready write stream or go out on a read stream.

Either side can end a burst. The device ends it by dropping its request while a strobe is low, and that pulse then carries the last word. The host ends it on its own when the local stream cannot supply or accept the next word. After either kind of end, the engine opens a new burst as soon as the request is high again and the stream is ready, and it keeps doing so until the remaining-word count reaches zero. At that point it raises a done flag.

Top module: `mdma_host_engine`

## Requirements
- R1: `dmack_n` goes low only in the cycle after `dmarq` was sampled high while a command with words left is loaded. With no command pending it stays high whatever `dmarq` does.
- R2: Each strobe (`dior_n` or `diow_n`, active low) stays low for exactly ASSERT clocks, which is 4 with the defaults. Between two pulses it stays high for at least NEG clocks, which is 2 with the defaults. The two strobes are never low together.
- R3: A strobe is low only while `dmack_n` is low. `dmack_n` is low for at least one cycle before the first pulse of a burst, and it stays low for at least one cycle after the last pulse negates.
- R4: A write command (`cmd_write`=1) uses `diow_n`. Each pulse drives on `dd_out` the next word taken from the write stream, in order. A word is taken when `wr_valid` and `wr_ready` are both high. The word stays on `dd_out` through the pulse and the cycle after it, and `dd_oe` is high throughout.
- R5: A read command (`cmd_write`=0) uses `dior_n`. The value of `dd_in` in the last cycle of each pulse appears on `rd_data` with a one-cycle `rd_valid` pulse, in bus order.
- R6: If `dmarq` is low in any cycle of a pulse, that pulse is the last one of the burst. `dmack_n` rises one cycle after the strobe negates. The next pulse comes only after `dmarq` is high again and a new burst opens.
- R7: The host ends a burst when, at the point where the next pulse would start, the write stream has no valid word or `rd_ready` is low. `dmack_n` returns high while `busy` stays high, and the transfer resumes once the stream is ready.
- R8: A command moves exactly `cmd_words` words. `cmd_done` rises when the last burst closes and clears on the next accepted load. A load with a count of zero sets `cmd_done` at once. A load while `busy` is high is ignored.
- R9: After reset, `dmack_n`, `dior_n` and `diow_n` are high, and `dd_oe`, `rd_valid`, `busy` and `cmd_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock (48 MHz nominal) |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Load a new command when not busy |
| cmd_words | input | CNT_W | Number of words in the command |
| cmd_write | input | 1 | 1: host-to-device, 0: device-to-host |
| busy | output | 1 | Command in progress |
| cmd_done | output | 1 | Command finished |
| wr_valid | input | 1 | Write stream word available |
| wr_data | input | DATA_W | Write stream word |
| wr_ready | output | 1 | Write word taken this cycle |
| rd_valid | output | 1 | Read word valid (one cycle) |
| rd_data | output | DATA_W | Read word |
| rd_ready | input | 1 | Read sink can take the next word |
| dmarq | input | 1 | Device DMA request |
| dmack_n | output | 1 | DMA acknowledge, active low |
| dior_n | output | 1 | Read strobe, active low |
| diow_n | output | 1 | Write strobe, active low |
| dd_out | output | DATA_W | Bus data driven by host |
| dd_oe | output | 1 | Bus output enable |
| dd_in | input | DATA_W | Bus data from device |

## Verification
The bench builds the engine with its default parameters: a 16-bit bus, a 16-bit counter and the 48 MHz timing, which gives 4-clock pulses, 2-clock recovery and 1-clock acknowledge margins. These small cycle counts let a few hundred clocks cover many bursts. In those bursts the behavioural device drops its request at random in the middle of pulses, and the local streams stall at random. Directed cases cover stalled streams with the request held high, a request with no command loaded, zero-length commands and loads attempted while busy.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER,
    ST_HOLD
  } mdma_state_t;

  // Round a time in ns up to whole periods of a clk_mhz clock.
  function automatic int ns_to_clk(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/mdma_down_timer.sv
module mdma_down_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/mdma_word_counter.sv
module mdma_word_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         is_zero,
  output logic         is_last
);
  logic [W-1:0] remaining;

  always_ff @(posedge clk) begin
    if (rst)                          remaining <= '0;
    else if (load)                    remaining <= load_val;
    else if (dec && remaining != '0)  remaining <= remaining - 1'b1;
  end

  assign is_zero = (remaining == '0);
  assign is_last = (remaining == W'(1));
endmodule

// File: rtl/mdma_host_engine.sv
module mdma_host_engine
  import mdma_pkg::*;
#(
  parameter int DATA_W         = 16,
  parameter int CNT_W          = 16,
  parameter int CLK_MHZ        = 48,
  parameter int T_ASSERT_NS    = 80,
  parameter int T_NEG_NS       = 36,
  parameter int T_CYCLE_NS     = 120,
  parameter int T_ACK_SETUP_NS = 18,
  parameter int T_ACK_HOLD_NS  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_load,
  input  logic [CNT_W-1:0]  cmd_words,
  input  logic              cmd_write,
  output logic              busy,
  output logic              cmd_done,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready,
  input  logic              dmarq,
  output logic              dmack_n,
  output logic              dior_n,
  output logic              diow_n,
  output logic [DATA_W-1:0] dd_out,
  output logic              dd_oe,
  input  logic [DATA_W-1:0] dd_in
);
  localparam int ASSERT_CLK = at_least_one(ns_to_clk(T_ASSERT_NS, CLK_MHZ));
  localparam int NEG_MIN    = at_least_one(ns_to_clk(T_NEG_NS, CLK_MHZ));
  localparam int CYCLE_CLK  = ns_to_clk(T_CYCLE_NS, CLK_MHZ);
  localparam int NEG_CLK    = max_of(NEG_MIN, CYCLE_CLK - ASSERT_CLK);
  localparam int SETUP_CLK  = at_least_one(ns_to_clk(T_ACK_SETUP_NS, CLK_MHZ));
  localparam int HOLD_CLK   = at_least_one(ns_to_clk(T_ACK_HOLD_NS, CLK_MHZ));
  localparam int TMR_MAX    = max_of(max_of(ASSERT_CLK, NEG_CLK), max_of(SETUP_CLK, HOLD_CLK));
  localparam int TMR_W      = $clog2(TMR_MAX + 1);

  mdma_state_t state, nxt;
  logic             dir_wr;
  logic             drop_seen;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val;
  logic             words_zero, words_last;
  logic             load_ok, stream_ok, start_req, pulse_go, pulse_end, burst_last;

  assign busy       = !words_zero || (state != ST_IDLE);
  assign load_ok    = cmd_load && !busy;
  assign stream_ok  = dir_wr ? wr_valid : rd_ready;
  assign start_req  = (state == ST_IDLE) && !words_zero && dmarq && stream_ok;
  assign pulse_go   = ((state == ST_SETUP) || (state == ST_RECOVER)) &&
                      tmr_zero && dmarq && stream_ok;
  assign pulse_end  = (state == ST_STROBE) && tmr_zero;
  assign burst_last = drop_seen || !dmarq || words_last;
  assign wr_ready   = dir_wr && pulse_go;

  mdma_down_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  mdma_word_counter #(.W(CNT_W)) u_words (
    .clk      (clk),
    .rst      (rst),
    .load     (load_ok),
    .load_val (cmd_words),
    .dec      (pulse_end),
    .is_zero  (words_zero),
    .is_last  (words_last)
  );

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (start_req) begin
        nxt = ST_SETUP;  tmr_load = 1'b1; tmr_val = TMR_W'(SETUP_CLK - 1);
      end
      ST_SETUP, ST_RECOVER: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (pulse_go) begin
          nxt = ST_STROBE; tmr_val = TMR_W'(ASSERT_CLK - 1);
        end else begin
          nxt = ST_HOLD;   tmr_val = TMR_W'(HOLD_CLK - 1);
        end
      end
      ST_STROBE: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (burst_last) begin
          nxt = ST_HOLD;    tmr_val = TMR_W'(HOLD_CLK - 1);
        end else begin
          nxt = ST_RECOVER; tmr_val = TMR_W'(NEG_CLK - 1);
        end
      end
      ST_HOLD: if (tmr_zero) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      dir_wr    <= 1'b0;
      drop_seen <= 1'b0;
      cmd_done  <= 1'b0;
      dmack_n   <= 1'b1;
      dior_n    <= 1'b1;
      diow_n    <= 1'b1;
      dd_oe     <= 1'b0;
      dd_out    <= '0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
    end else begin
      state     <= nxt;
      drop_seen <= (state == ST_STROBE) && !tmr_zero && (drop_seen || !dmarq);
      dmack_n   <= (nxt == ST_IDLE);
      dior_n    <= !((nxt == ST_STROBE) && !dir_wr);
      diow_n    <= !((nxt == ST_STROBE) && dir_wr);
      dd_oe     <= dir_wr && (nxt != ST_IDLE);
      rd_valid  <= pulse_end && !dir_wr;
      if (pulse_end && !dir_wr) rd_data <= dd_in;
      if (wr_ready)             dd_out  <= wr_data;
      if (load_ok) begin
        dir_wr   <= cmd_write;
        cmd_done <= (cmd_words == '0);
      end else if ((state == ST_HOLD) && tmr_zero && words_zero) begin
        cmd_done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mdma_host_checker.sv
module mdma_host_checker #(
  parameter int T_ASSERT = 4,
  parameter int T_NEG    = 2
) (
  input logic clk,
  input logic rst,
  input logic dmarq,
  input logic dmack_n,
  input logic dior_n,
  input logic diow_n,
  input logic cmd_done
);
  logic        strobe_idle;
  logic [15:0] lo_cnt, hi_cnt;
  logic        drop_seen;

  assign strobe_idle = dior_n && diow_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt    <= '0;
      hi_cnt    <= 16'hFFFF;
      drop_seen <= 1'b0;
    end else begin
      lo_cnt <= strobe_idle ? 16'd0 : lo_cnt + 16'd1;
      hi_cnt <= !strobe_idle ? 16'd0 : (hi_cnt == 16'hFFFF ? hi_cnt : hi_cnt + 16'd1);
      if (dmack_n)                          drop_seen <= 1'b0;
      else if (!strobe_idle && !dmarq)      drop_seen <= 1'b1;
    end
  end

  assert_ack_after_request_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(dmack_n) |-> $past(dmarq));

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(strobe_idle) |-> (lo_cnt == 16'(T_ASSERT)));

  assert_recovery_gap_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_idle) |-> (hi_cnt >= 16'(T_NEG)));

  assert_single_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    !(!dior_n && !diow_n));

  assert_strobe_inside_ack_R3: assert property (@(posedge clk) disable iff (rst)
    !strobe_idle |-> !dmack_n);

  assert_ack_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_idle) |-> !$past(dmack_n));

  assert_no_pulse_after_drop_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_idle) |-> !drop_seen);

  assert_done_means_released_R8: assert property (@(posedge clk) disable iff (rst)
    cmd_done |-> (dmack_n && strobe_idle));
endmodule

bind mdma_host_engine mdma_host_checker #(
  .T_ASSERT (ASSERT_CLK),
  .T_NEG    (NEG_CLK)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .dmarq    (dmarq),
  .dmack_n  (dmack_n),
  .dior_n   (dior_n),
  .diow_n   (diow_n),
  .cmd_done (cmd_done)
);

// File: tb/sim_mdma_host_engine.sv
module sim_mdma_host_engine;
  localparam int DW = 16;
  localparam int CW = 16;
  localparam int EXP_ASSERT = 4;
  localparam int EXP_NEG    = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_load = 1'b0;
  logic [CW-1:0] cmd_words = '0;
  logic          cmd_write = 1'b0;
  logic          busy, cmd_done, wr_ready, rd_valid;
  logic          wr_valid = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rd_ready = 1'b0;
  logic          dmarq = 1'b0;
  logic          dmack_n, dior_n, diow_n, dd_oe;
  logic [DW-1:0] dd_out;
  logic [DW-1:0] dd_in = 16'h5A00;

  always #4 clk = ~clk;

  mdma_host_engine u0 (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_words(cmd_words),
    .cmd_write(cmd_write), .busy(busy), .cmd_done(cmd_done),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_ready(rd_ready),
    .dmarq(dmarq), .dmack_n(dmack_n), .dior_n(dior_n), .diow_n(diow_n),
    .dd_out(dd_out), .dd_oe(dd_oe), .dd_in(dd_in)
  );

  int total = 0, bad = 0, cyc = 0;
  logic [DW-1:0] exp_q[$];

  // stimulus knobs
  bit dev_on = 0, drop_en = 0, wr_gap = 0, rd_gap = 0, rd_hold = 1;
  int wr_limit = 1000000, taken = 0;
  bit take_now = 0;

  // monitor state
  int  lo_n = 0, hi_n = 100, hold_n = 0;
  int  viol_r2 = 0, viol_r3 = 0, viol_r6 = 0, drops = 0, bursts = 0, words_seen = 0;
  bit  drop_flag = 0, prev_low = 0, prev_ack_n = 1, prev_wlow = 0, prev_rlow = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // device model and local stream driver (inputs change 1 time unit after the edge)
  always @(posedge clk) begin
    #1;
    if (!dev_on) dmarq = 1'b0;
    else if (dmarq) begin
      if (drop_en && (!dior_n || !diow_n) && ($urandom % 6 == 0)) dmarq = 1'b0;
    end else if ($urandom % 3 == 0) dmarq = 1'b1;
    if (dior_n && prev_rlow) begin
      exp_q.push_back(dd_in);
      dd_in = dd_in + 16'h0107;
    end
    prev_rlow = !dior_n;
    if (take_now) begin
      taken++;
      take_now = 0;
    end
    wr_data  = DW'(taken * 16'h1357) ^ 16'h00C3;
    wr_valid = (taken < wr_limit) && (!wr_gap || ($urandom % 3 != 0));
    rd_ready = rd_gap ? ($urandom % 3 != 0) : rd_hold;
  end

  // scoreboard monitor, sampling away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      logic s_low;
      s_low = !dior_n || !diow_n;
      if (wr_valid && wr_ready) begin
        exp_q.push_back(wr_data);
        take_now = 1;
      end
      if (s_low && dmack_n) viol_r3++;
      if (s_low) begin
        if (!prev_low) begin
          if (prev_ack_n) viol_r3++;
          if (drop_flag) viol_r6++;
          if (hi_n < EXP_NEG) viol_r2++;
          lo_n = 0;
        end
        lo_n++;
      end else begin
        if (prev_low) begin
          if (lo_n != EXP_ASSERT) viol_r2++;
          hi_n = 0;
        end
        hi_n++;
      end
      if (!dmack_n && prev_ack_n) bursts++;
      if (dmack_n && !prev_ack_n && prev_low) viol_r3++;
      if (s_low && !dmarq) begin
        if (!drop_flag) drops++;
        drop_flag = 1;
      end
      if (drop_flag && !s_low && !dmack_n) begin
        hold_n++;
        if (hold_n == 2) viol_r6++;
      end
      if (dmack_n) begin
        drop_flag = 0;
        hold_n = 0;
      end
      if (diow_n && prev_wlow) begin
        logic [DW-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
        words_seen++;
        chk(dd_out == e && dd_oe, "R4 write word on bus", int'(dd_out), int'(e));
      end
      if (rd_valid) begin
        logic [DW-1:0] e;
        e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hDEAD;
        words_seen++;
        chk(rd_data == e, "R5 read word delivered", int'(rd_data), int'(e));
      end
      prev_low   = s_low;
      prev_ack_n = dmack_n;
      prev_wlow  = !diow_n;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic load_cmd(input int n, input bit wr);
    @(posedge clk); #1;
    cmd_words = CW'(n); cmd_write = wr; cmd_load = 1'b1;
    @(posedge clk); #1;
    cmd_load = 1'b0;
  endtask

  task automatic wait_done();
    while (!cmd_done) @(posedge clk);
    repeat (3) @(posedge clk);
  endtask

  task automatic run_cmd(input int n, input bit wr, input string tag);
    words_seen = 0;
    load_cmd(n, wr);
    wait_done();
    @(negedge clk);
    chk(words_seen == n, {tag, " words moved"}, words_seen, n);
    chk(cmd_done && !busy && dmack_n, {tag, " done raised"}, int'(cmd_done), 1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dmack_n && dior_n && diow_n, "R9 bus idle in reset", int'({dmack_n, dior_n, diow_n}), 7);
    chk(!dd_oe && !rd_valid && !busy && !cmd_done, "R9 flags low in reset",
        int'({dd_oe, rd_valid, busy, cmd_done}), 0);
    @(posedge clk); #1 rst = 1'b0;

    // R1: request with nothing loaded
    dev_on = 1;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(dmack_n && dmarq, "R1 no ack without command", int'(dmack_n), 1);

    // steady write, steady read (R2 R3 R4 R5 R8)
    run_cmd(20, 1'b1, "R8 write steady");
    chk(exp_q.size() == 0, "R4 write queue drained", exp_q.size(), 0);
    run_cmd(24, 1'b0, "R8 read steady");

    // device drops (R6)
    drop_en = 1;
    bursts = 0; drops = 0;
    run_cmd(40, 1'b0, "R6 read with drops");
    chk(drops > 0 && bursts > 1, "R6 drops caused resumed bursts", bursts, 2);
    run_cmd(40, 1'b1, "R6 write with drops");

    // random stream stalls (R7)
    wr_gap = 1; rd_gap = 1;
    run_cmd(30, 1'b1, "R7 write with stalls");
    run_cmd(30, 1'b0, "R7 read with stalls");
    wr_gap = 0; rd_gap = 0; drop_en = 0;

    // R7 directed write: stream runs dry after 3 words
    taken = 0; wr_limit = 3; words_seen = 0;
    load_cmd(12, 1'b1);
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(dmack_n && dmarq && busy, "R7 host releases ack when write stream dry",
        int'({dmack_n, dmarq, busy}), 7);
    chk(words_seen == 3, "R7 no pulse without write word", words_seen, 3);
    wr_limit = 1000000;
    wait_done();
    @(negedge clk);
    chk(words_seen == 12, "R7 write resumes to full count", words_seen, 12);

    // R7 directed read: sink not ready
    rd_hold = 0; words_seen = 0;
    load_cmd(8, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(dmack_n && busy && words_seen == 0, "R7 no read burst while sink busy",
        words_seen, 0);
    rd_hold = 1;
    wait_done();
    @(negedge clk);
    chk(words_seen == 8, "R7 read resumes to full count", words_seen, 8);

    // R8 zero-length command
    words_seen = 0;
    load_cmd(0, 1'b0);
    @(negedge clk);
    chk(cmd_done && !busy && dmack_n, "R8 zero count completes at once", int'(cmd_done), 1);
    repeat (10) @(posedge clk);
    @(negedge clk);
    chk(words_seen == 0 && dmack_n, "R8 zero count moves nothing", words_seen, 0);

    // R8 load while busy is ignored
    words_seen = 0;
    load_cmd(6, 1'b0);
    repeat (2) @(posedge clk);
    @(posedge clk); #1;
    cmd_words = CW'(50); cmd_write = 1'b1; cmd_load = 1'b1;
    @(posedge clk); #1 cmd_load = 1'b0;
    wait_done();
    @(negedge clk);
    chk(words_seen == 6, "R8 load while busy ignored", words_seen, 6);

    chk(viol_r2 == 0, "R2 pulse width and gap", viol_r2, 0);
    chk(viol_r3 == 0, "R3 ack envelope", viol_r3, 0);
    chk(viol_r6 == 0, "R6 last pulse after drop", viol_r6, 0);
    chk(exp_q.size() == 0, "R5 scoreboard empty", exp_q.size(), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule